// File: doc/BRIEF.md
# Banked cartridge memory mapper

This block sits between a console's CPU and video buses and the memories on a cartridge board. On the CPU side it splits the upper 40 KiB of the address space into five 8 KiB windows. Four of them are switchable: each one goes to program ROM or to work RAM, chosen by a bank register. The fifth window is fixed to the last ROM bank. On the video side it splits the 8 KiB pattern area into eight 1 KiB windows into character memory. It also folds the nametable area onto 2 KiB of console RAM, using one of four mirroring modes.

Software reaches the registers through two addresses. The first write goes to the command address and picks a register index. A second write, to the data address, loads the register that index selects. All decoding from address to memory is combinational. The outputs are the translated addresses, a chip select for each memory, a write enable for work RAM and a flag that marks reads which no memory answers (open bus).

Top module: `cart_mapper`

## Requirements
- R1: A CPU write (cpu_wr high at a rising clock) to exactly 0x8000 stores cpu_data[3:0] as the command index; from the next cycle on, a write to exactly 0xA000 loads the register that index selects. The upper data bits and writes to any other address, such as 0x8001, leave the index unchanged.
- R2: Indices 0..7 load the character bank registers. For a video address with bit 13 clear, chr_cs is 1 and chr_addr = {bank[ppu_addr[12:10]], ppu_addr[9:0]}.
- R3: Indices 8..11 load the program bank registers of the windows at 0x6000, 0x8000, 0xA000 and 0xC000, in that order. A read in such a window whose register has bit 6 clear gives prg_rom_cs = 1 and prg_rom_addr = {reg[5:0], cpu_addr[12:0]}.
- R4: A read in 0xE000..0xFFFF always selects ROM bank 0x3F: prg_rom_cs = 1 and prg_rom_addr = {6'h3F, cpu_addr[12:0]}.
- R5: In a program bank register, bit 6 selects RAM and bit 7 enables it. A read with both bits set gives wram_cs = 1 and wram_addr = cpu_addr[12:0]. A read with bit 6 set and bit 7 clear gives open_bus = 1 and no chip select.
- R6: Reads below 0x6000 give open_bus = 1, with prg_rom_cs and wram_cs both 0.
- R7: Every write in 0x6000..0x7FFF gives wram_cs = 1 and wram_we = 1 at cpu_addr[12:0], whatever the bank register holds. Writes elsewhere assert no chip select, no write enable and no open_bus.
- R8: Index 12 loads a 2-bit mirroring mode from cpu_data[1:0]. A video address with bit 13 set gives ntram_cs = 1 and ntram_addr = {page, ppu_addr[9:0]}. The page is ppu_addr[10] in mode 0, ppu_addr[11] in mode 1, 0 in mode 2 and 1 in mode 3.
- R9: Data writes with index 13, 14 or 15 change no output mapping.
- R10: A synchronous reset clears the command index, all bank registers and the mirroring mode to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_addr | input | 16 | CPU address |
| cpu_data | input | 8 | CPU write data |
| cpu_wr | input | 1 | CPU write strobe (1 = write, 0 = read) |
| ppu_addr | input | 14 | Video bus address |
| prg_rom_addr | output | 19 | Program ROM address |
| prg_rom_cs | output | 1 | Program ROM select (reads only) |
| wram_addr | output | 13 | Work RAM address |
| wram_cs | output | 1 | Work RAM select |
| wram_we | output | 1 | Work RAM write enable |
| open_bus | output | 1 | No memory drives this read |
| chr_addr | output | 18 | Character memory address |
| chr_cs | output | 1 | Character memory select |
| ntram_addr | output | 11 | Nametable RAM address |
| ntram_cs | output | 1 | Nametable RAM select |

## Verification
The bench sweeps the entire video address space under every mirroring mode. A design that swaps address bit 10 for bit 11, or gets a forced page wrong, shows mismatches across whole quarters of the sweep. It sweeps CPU reads over all five windows with bank registers set to ROM, enabled RAM and disabled RAM. This exposes a window that uses the wrong register, a swapped meaning of bits 6 and 7, and an E000 window that is not fixed. It also issues writes next to the port addresses (0x8001, 0xA001) and data writes with the unused indices. A design that decodes only part of the address, or that aliases indices 13..15 onto real registers, then changes mappings that later sweeps compare against.

// File: rtl/mapper_pkg.sv
package mapper_pkg;
    localparam int CPU_AW     = 16;
    localparam int PPU_AW     = 14;
    localparam int DW         = 8;
    localparam int CMD_W      = 4;
    localparam int NUM_CHR    = 8;
    localparam int NUM_PRG    = 4;
    localparam int PRG_BANK_W = 6;
    localparam int PRG_WIN_W  = 13;
    localparam int CHR_WIN_W  = 10;
    localparam int NT_AW      = CHR_WIN_W + 1;
    localparam int PRG_ROM_AW = PRG_BANK_W + PRG_WIN_W;
    localparam int CHR_AW     = DW + CHR_WIN_W;
    localparam int WIN_SEL_W  = CPU_AW - PRG_WIN_W;

    localparam int PRG_IDX_BASE = NUM_CHR;
    localparam int MIRROR_IDX   = NUM_CHR + NUM_PRG;
    localparam int FIRST_WIN    = 3;
    localparam int FIXED_WIN    = FIRST_WIN + NUM_PRG;

    localparam logic [CPU_AW-1:0]     CMD_PORT   = 16'h8000;
    localparam logic [CPU_AW-1:0]     DATA_PORT  = 16'hA000;
    localparam logic [PRG_BANK_W-1:0] FIXED_BANK = '1;

    typedef enum logic [1:0] {
        MIR_VERT  = 2'd0,
        MIR_HORZ  = 2'd1,
        MIR_PAGE0 = 2'd2,
        MIR_PAGE1 = 2'd3
    } mirror_e;

    typedef struct packed {
        logic                  ram_en;
        logic                  ram_sel;
        logic [PRG_BANK_W-1:0] bank;
    } prg_reg_t;

    function automatic logic nt_page(mirror_e m, logic [PPU_AW-1:0] a);
        case (m)
            MIR_VERT:  return a[10];
            MIR_HORZ:  return a[11];
            MIR_PAGE0: return 1'b0;
            default:   return 1'b1;
        endcase
    endfunction
endpackage

// File: rtl/mapper_regfile.sv
module mapper_regfile
    import mapper_pkg::*;
#(
    parameter int N_CHR = NUM_CHR,
    parameter int N_PRG = NUM_PRG
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      cpu_wr,
    input  logic [CPU_AW-1:0]         cpu_addr,
    input  logic [DW-1:0]             cpu_data,
    output logic [N_CHR-1:0][DW-1:0]  chr_banks,
    output prg_reg_t [N_PRG-1:0]      prg_banks,
    output mirror_e                   mirror
);
    logic [CMD_W-1:0]         cmd_q;
    logic [N_CHR-1:0][DW-1:0] chr_q;
    prg_reg_t [N_PRG-1:0]     prg_q;
    mirror_e                  mir_q;

    logic cmd_wr, data_wr;
    assign cmd_wr  = cpu_wr && (cpu_addr == CMD_PORT);
    assign data_wr = cpu_wr && (cpu_addr == DATA_PORT);

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_q <= '0;
            chr_q <= '0;
            prg_q <= '0;
            mir_q <= MIR_VERT;
        end else begin
            if (cmd_wr)
                cmd_q <= cpu_data[CMD_W-1:0];
            if (data_wr) begin
                for (int i = 0; i < N_CHR; i++)
                    if (cmd_q == CMD_W'(i))
                        chr_q[i] <= cpu_data;
                for (int j = 0; j < N_PRG; j++)
                    if (cmd_q == CMD_W'(PRG_IDX_BASE + j))
                        prg_q[j] <= prg_reg_t'(cpu_data);
                if (cmd_q == CMD_W'(MIRROR_IDX))
                    mir_q <= mirror_e'(cpu_data[1:0]);
            end
        end
    end

    assign chr_banks = chr_q;
    assign prg_banks = prg_q;
    assign mirror    = mir_q;

    // R1: command index follows the low data bits of a command-port write
    p_cmd_latch_r1: assert property (@(posedge clk) disable iff (rst)
        cmd_wr |=> cmd_q == $past(cpu_data[CMD_W-1:0]));

    // R2: character banks change only on a data write with index 0..7
    p_chr_hold_r2: assert property (@(posedge clk) disable iff (rst)
        !(data_wr && cmd_q < CMD_W'(N_CHR)) |=> $stable(chr_q));

    // R3: program banks change only on a data write with index 8..11
    p_prg_hold_r3: assert property (@(posedge clk) disable iff (rst)
        !(data_wr && cmd_q >= CMD_W'(PRG_IDX_BASE) && cmd_q < CMD_W'(MIRROR_IDX))
        |=> $stable(prg_q));

    // R8: mirroring mode changes only on a data write with index 12
    p_mir_hold_r8: assert property (@(posedge clk) disable iff (rst)
        !(data_wr && cmd_q == CMD_W'(MIRROR_IDX)) |=> $stable(mir_q));
endmodule

// File: rtl/mapper_prg_map.sv
module mapper_prg_map
    import mapper_pkg::*;
#(
    parameter int N_PRG = NUM_PRG
) (
    input  logic [CPU_AW-1:0]     cpu_addr,
    input  logic                  cpu_wr,
    input  prg_reg_t [N_PRG-1:0]  prg_banks,
    output logic [PRG_ROM_AW-1:0] rom_addr,
    output logic                  rom_cs,
    output logic [PRG_WIN_W-1:0]  wram_addr,
    output logic                  wram_cs,
    output logic                  wram_we,
    output logic                  open_bus
);
    logic [WIN_SEL_W-1:0] win;
    logic [N_PRG-1:0]     win_hit;
    logic                 in_map;
    logic                 in_ram_win;
    prg_reg_t             sel;

    assign win        = cpu_addr[CPU_AW-1:PRG_WIN_W];
    assign in_map     = win >= WIN_SEL_W'(FIRST_WIN);
    assign in_ram_win = win == WIN_SEL_W'(FIRST_WIN);

    for (genvar g = 0; g < N_PRG; g++) begin : g_win
        assign win_hit[g] = (win == WIN_SEL_W'(FIRST_WIN + g));
    end

    always_comb begin
        sel = '{ram_en: 1'b0, ram_sel: 1'b0, bank: FIXED_BANK};
        for (int k = 0; k < N_PRG; k++)
            if (win_hit[k])
                sel = prg_banks[k];
    end

    assign rom_addr  = {sel.bank, cpu_addr[PRG_WIN_W-1:0]};
    assign wram_addr = cpu_addr[PRG_WIN_W-1:0];

    always_comb begin
        if (cpu_wr) begin
            rom_cs   = 1'b0;
            open_bus = 1'b0;
            wram_cs  = in_ram_win;
            wram_we  = in_ram_win;
        end else begin
            wram_we  = 1'b0;
            rom_cs   = in_map && !sel.ram_sel;
            wram_cs  = in_map && sel.ram_sel && sel.ram_en;
            open_bus = !in_map || (sel.ram_sel && !sel.ram_en);
        end
    end
endmodule

// File: rtl/mapper_chr_map.sv
module mapper_chr_map
    import mapper_pkg::*;
#(
    parameter int N_CHR = NUM_CHR
) (
    input  logic [PPU_AW-1:0]        ppu_addr,
    input  logic [N_CHR-1:0][DW-1:0] chr_banks,
    input  mirror_e                  mirror,
    output logic [CHR_AW-1:0]        chr_addr,
    output logic                     chr_cs,
    output logic [NT_AW-1:0]         nt_addr,
    output logic                     nt_cs
);
    localparam int SLOT_W = $clog2(N_CHR);

    logic [SLOT_W-1:0] slot;
    assign slot = ppu_addr[CHR_WIN_W +: SLOT_W];

    assign chr_addr = {chr_banks[slot], ppu_addr[CHR_WIN_W-1:0]};
    assign chr_cs   = !ppu_addr[PPU_AW-1];
    assign nt_cs    = ppu_addr[PPU_AW-1];
    assign nt_addr  = {nt_page(mirror, ppu_addr), ppu_addr[CHR_WIN_W-1:0]};
endmodule

// File: rtl/cart_mapper.sv
module cart_mapper
    import mapper_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic [15:0] cpu_addr,
    input  logic [7:0]  cpu_data,
    input  logic        cpu_wr,
    input  logic [13:0] ppu_addr,
    output logic [18:0] prg_rom_addr,
    output logic        prg_rom_cs,
    output logic [12:0] wram_addr,
    output logic        wram_cs,
    output logic        wram_we,
    output logic        open_bus,
    output logic [17:0] chr_addr,
    output logic        chr_cs,
    output logic [10:0] ntram_addr,
    output logic        ntram_cs
);
    logic [NUM_CHR-1:0][DW-1:0] chr_banks;
    prg_reg_t [NUM_PRG-1:0]     prg_banks;
    mirror_e                    mirror;

    mapper_regfile #(.N_CHR(NUM_CHR), .N_PRG(NUM_PRG)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .cpu_wr    (cpu_wr),
        .cpu_addr  (cpu_addr),
        .cpu_data  (cpu_data),
        .chr_banks (chr_banks),
        .prg_banks (prg_banks),
        .mirror    (mirror)
    );

    mapper_prg_map #(.N_PRG(NUM_PRG)) u_prg (
        .cpu_addr  (cpu_addr),
        .cpu_wr    (cpu_wr),
        .prg_banks (prg_banks),
        .rom_addr  (prg_rom_addr),
        .rom_cs    (prg_rom_cs),
        .wram_addr (wram_addr),
        .wram_cs   (wram_cs),
        .wram_we   (wram_we),
        .open_bus  (open_bus)
    );

    mapper_chr_map #(.N_CHR(NUM_CHR)) u_chr (
        .ppu_addr  (ppu_addr),
        .chr_banks (chr_banks),
        .mirror    (mirror),
        .chr_addr  (chr_addr),
        .chr_cs    (chr_cs),
        .nt_addr   (ntram_addr),
        .nt_cs     (ntram_cs)
    );

    // R5: at most one of ROM, RAM and open bus per access
    p_one_target_r5: assert property (@(posedge clk) disable iff (rst)
        $onehot0({prg_rom_cs, wram_cs, open_bus}));

    // R4: the top window reads the fixed last bank
    p_fixed_top_r4: assert property (@(posedge clk) disable iff (rst)
        (!cpu_wr && cpu_addr[15:13] == 3'd7) |-> (prg_rom_cs && prg_rom_addr[18:13] == 6'h3F));

    // R6: reads under 0x6000 are open bus
    p_low_open_r6: assert property (@(posedge clk) disable iff (rst)
        (!cpu_wr && cpu_addr < 16'h6000) |-> (open_bus && !prg_rom_cs && !wram_cs));

    // R7: writes outside the RAM window never enable a RAM write
    p_we_window_r7: assert property (@(posedge clk) disable iff (rst)
        (cpu_wr && cpu_addr[15:13] != 3'd3) |-> !wram_we);
endmodule

// File: tb/cart_mapper_tb.sv
module cart_mapper_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] cpu_addr = 16'h0000;
    logic [7:0]  cpu_data = 8'h00;
    logic        cpu_wr = 1'b0;
    logic [13:0] ppu_addr = 14'h0000;
    logic [18:0] prg_rom_addr;
    logic        prg_rom_cs;
    logic [12:0] wram_addr;
    logic        wram_cs, wram_we, open_bus;
    logic [17:0] chr_addr;
    logic        chr_cs;
    logic [10:0] ntram_addr;
    logic        ntram_cs;

    int n_run = 0;
    int n_fail = 0;
    int cycles = 0;
    bit done = 0;

    logic [7:0] m_chr [8];
    logic [7:0] m_prg [4];
    logic [1:0] m_mir;
    logic [3:0] m_cmd;

    always #2 clk = ~clk;

    cart_mapper dut_i (
        .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .cpu_data(cpu_data), .cpu_wr(cpu_wr),
        .ppu_addr(ppu_addr), .prg_rom_addr(prg_rom_addr), .prg_rom_cs(prg_rom_cs),
        .wram_addr(wram_addr), .wram_cs(wram_cs), .wram_we(wram_we), .open_bus(open_bus),
        .chr_addr(chr_addr), .chr_cs(chr_cs), .ntram_addr(ntram_addr), .ntram_cs(ntram_cs)
    );

    task automatic check(string req, logic [63:0] act, logic [63:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
            finish_run();
        end
    end

    task automatic model_reset();
        foreach (m_chr[i]) m_chr[i] = 8'h00;
        foreach (m_prg[i]) m_prg[i] = 8'h00;
        m_mir = 2'd0;
        m_cmd = 4'd0;
    endtask

    task automatic bus_write(logic [15:0] a, logic [7:0] d);
        @(negedge clk);
        cpu_addr = a; cpu_data = d; cpu_wr = 1'b1;
        @(negedge clk);
        cpu_wr = 1'b0;
        if (a == 16'h8000) m_cmd = d[3:0];
        else if (a == 16'hA000) begin
            if (m_cmd < 4'd8) m_chr[m_cmd[2:0]] = d;
            else if (m_cmd < 4'd12) m_prg[m_cmd[1:0]] = d;
            else if (m_cmd == 4'd12) m_mir = d[1:0];
        end
    endtask

    task automatic set_reg(logic [3:0] idx, logic [7:0] d);
        bus_write(16'h8000, {4'hA, idx});
        bus_write(16'hA000, d);
    endtask

    // Expected read result: {rom_cs, wram_cs, open_bus, wram_we, rom_addr, wram_addr}
    function automatic logic [63:0] exp_read(logic [15:0] a);
        logic [2:0] w = a[15:13];
        logic [7:0] b;
        if (w < 3'd3) return {1'b0, 1'b0, 1'b1, 1'b0, 19'd0, 13'd0};
        b = (w == 3'd7) ? 8'h3F : m_prg[w - 3'd3];
        if (b[6]) begin
            if (b[7]) return {1'b0, 1'b1, 1'b0, 1'b0, 19'd0, a[12:0]};
            return {1'b0, 1'b0, 1'b1, 1'b0, 19'd0, 13'd0};
        end
        return {1'b1, 1'b0, 1'b0, 1'b0, b[5:0], a[12:0], 13'd0};
    endfunction

    function automatic logic [63:0] act_cpu();
        return {prg_rom_cs, wram_cs, open_bus, wram_we,
                prg_rom_cs ? prg_rom_addr : 19'd0, wram_cs ? wram_addr : 13'd0};
    endfunction

    function automatic string read_tag(logic [15:0] a);
        if (a < 16'h6000) return "R6 low read";
        if (a >= 16'hE000) return "R4 fixed window";
        return "R3/R5 banked read";
    endfunction

    task automatic sweep_reads();
        for (int i = 0; i < 4096; i++) begin
            cpu_wr = 1'b0;
            cpu_addr = 16'(i * 16 + (i % 16));
            #1;
            check(read_tag(cpu_addr), act_cpu(), exp_read(cpu_addr));
        end
    endtask

    // Expected video result: {chr_cs, nt_cs, chr_addr, nt_addr}
    function automatic logic [63:0] exp_video(logic [13:0] a);
        logic pg;
        if (!a[13]) return {1'b1, 1'b0, m_chr[a[12:10]], a[9:0], 11'd0};
        case (m_mir)
            2'd0: pg = a[10];
            2'd1: pg = a[11];
            2'd2: pg = 1'b0;
            default: pg = 1'b1;
        endcase
        return {1'b0, 1'b1, 18'd0, pg, a[9:0]};
    endfunction

    task automatic sweep_video(string tag);
        for (int i = 0; i < 16384; i++) begin
            ppu_addr = 14'(i);
            #1;
            check(tag, {chr_cs, ntram_cs, chr_cs ? chr_addr : 18'd0, ntram_cs ? ntram_addr : 11'd0},
                  exp_video(ppu_addr));
        end
    endtask

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R10: reset state
        @(negedge clk);
        cpu_addr = 16'h6123; #1;
        check("R10 reset prg bank", act_cpu(), {1'b1, 1'b0, 1'b0, 1'b0, 6'd0, 13'h0123, 13'd0});
        ppu_addr = 14'h2C05; #1;
        check("R10 reset mirroring", {ntram_cs, ntram_addr}, {1'b1, 11'h405});
        ppu_addr = 14'h1ABC; #1;
        check("R10 reset chr bank", {chr_cs, chr_addr}, {1'b1, 8'h00, 10'h2BC});

        // R2 / R3 / R5: load banks
        for (int i = 0; i < 8; i++) set_reg(4'(i), 8'(i * 29 + 3));
        set_reg(4'd8, 8'h05);
        set_reg(4'd9, 8'h2A);
        set_reg(4'd10, 8'hC0);
        set_reg(4'd11, 8'h47);
        sweep_reads();

        // R8: every mirroring mode, upper data bits ignored
        for (int m = 0; m < 4; m++) begin
            set_reg(4'd12, 8'(8'hFC | m));
            sweep_video($sformatf("R8/R2 video mode %0d", m));
        end

        // R7: writes across the CPU space, avoiding the exact port addresses
        for (int i = 0; i < 4096; i++) begin
            @(negedge clk);
            cpu_addr = 16'(i * 16 + 1); cpu_data = 8'h5A; cpu_wr = 1'b1;
            #1;
            if (cpu_addr[15:13] == 3'd3)
                check("R7 ram window write", act_cpu(), {1'b0, 1'b1, 1'b0, 1'b1, 19'd0, cpu_addr[12:0]});
            else
                check("R7 write elsewhere", act_cpu(), 64'd0);
        end
        @(negedge clk);
        cpu_wr = 1'b0;
        sweep_reads();

        // R9: unused indices change nothing
        set_reg(4'd13, 8'hFF);
        set_reg(4'd14, 8'h77);
        set_reg(4'd15, 8'h33);
        sweep_reads();
        sweep_video("R9 video after unused indices");

        // R1: index latch masks upper bits, 0x8001 is not the command port
        bus_write(16'h8000, 8'hF9);
        bus_write(16'hA000, 8'h11);
        cpu_addr = 16'h8456; #1;
        check("R1 index from low bits", act_cpu(), exp_read(16'h8456));
        check("R1 bank value", {45'd0, prg_rom_addr}, {45'd0, 6'h11, 13'h0456});
        bus_write(16'h8000, 8'h03);
        bus_write(16'h8001, 8'h09);
        bus_write(16'hA001, 8'h99);
        bus_write(16'hA000, 8'h77);
        ppu_addr = 14'h0C12; #1;
        check("R1 near-address writes ignored", {chr_cs, chr_addr}, {1'b1, 8'h77, 10'h012});
        sweep_reads();

        // R10: reset again clears everything
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        model_reset();
        sweep_reads();
        sweep_video("R10 video after reset");

        finish_run();
    end
endmodule